// File: doc/BRIEF.md
# Segment-Driven I2C Bus Master

This block is an I2C bus master that does not sequence whole transfers by itself. Software builds each frame out of single segments: a START (or a repeated START when the bus is already owned), the transmission of one byte, the reception of one byte, and a STOP. Each segment is launched by a one-cycle command strobe. A matching busy bit stays high while the segment runs and clears itself when the segment ends. Completion status flags and two interrupt pulses give software other ways to learn that a segment has finished.

Software places one byte in a transmit holding register before a transmit segment. A receive segment leaves its byte in a receive holding register. Address bytes are formed by software and sent as ordinary transmit segments. A 7-bit address goes out as the address in bits [7:1] and the read/write flag in bit 0. A 10-bit address takes two bytes: first `11110`, then address bits [9:8], then read/write, and then a second byte with the low eight address bits. The bus pins are open drain. An output-enable high pulls a line low. A fixed divider splits every bus bit into four quarter periods.

The controller has five states. In IDLE the bus is free. In HOLD the bus is owned with SCL low. START, BIT and STOP each run through four quarter-phases. The transitions are:
- IDLE to START on an accepted start.
- HOLD to START on an accepted start (a repeated START).
- HOLD to BIT on an accepted send or receive.
- HOLD to STOP on an accepted stop.
- START to HOLD and BIT to HOLD after the last quarter of the segment.
- STOP to IDLE after its last quarter.

Top module: `i2c_seg_master`

## Requirements
- R1: After reset all busy bits, status flags, interrupt outputs, `rx_byte`, `scl_oe` and `sda_oe` are 0, so both bus lines are released.
- R2: A start strobe on a free bus makes SDA fall while SCL is high. SCL is then held low. `busy_start` is 1 from the cycle after the strobe until the segment ends, and it then clears itself with `done_cmd` set.
- R3: A send segment shifts out the transmit holding register MSB first on eight SCL pulses. SDA never changes while SCL is high. Completion clears `busy_send` and sets `done_tx` and `done_cmd`.
- R4: On the ninth SCL pulse of a send, the master releases SDA. `nack_flag` takes 1 if the slave left SDA high and 0 if it pulled SDA low. A NACK also produces a one-cycle `irq_nack` pulse.
- R5: A receive segment samples eight bits MSB first into `rx_byte`. On the ninth pulse the master pulls SDA low when `ack_en` is 1 and leaves it released when `ack_en` is 0. Completion sets `done_rx`.
- R6: A stop segment pulls SDA low, releases SCL, then releases SDA while SCL is high. Both lines end released and the bus is free.
- R7: A start strobe while the bus is held first releases SDA with SCL low, then raises SCL, then pulls SDA low while SCL is high. This is a repeated START.
- R8: A strobe is ignored while any segment is busy. Stop, send and receive strobes are ignored while the bus is free. When several strobes arrive in one cycle, only the highest one in the order start, stop, send, receive is considered.
- R9: An accepted command clears `done_cmd`. An accepted send also clears `done_tx` and `nack_flag`, and an accepted receive clears `done_rx`. Flags of other kinds keep their value.
- R10: `irq_done` is a one-cycle pulse on each 0-to-1 transition of `done_cmd`.
- R11: While SCL is released, the high quarter does not begin until `scl_in` reads high. A slave holding SCL low therefore stalls the segment without corrupting it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_start | input | 1 | Start / repeated-start strobe |
| cmd_stop | input | 1 | Stop strobe |
| cmd_send | input | 1 | Transmit-byte strobe |
| cmd_recv | input | 1 | Receive-byte strobe |
| tx_wr | input | 1 | Load `tx_wdata` into the transmit holding register |
| tx_wdata | input | 8 | Byte for the next send |
| ack_en | input | 1 | 1: acknowledge received bytes; 0: answer with NACK |
| busy_start | output | 1 | Start segment in progress |
| busy_stop | output | 1 | Stop segment in progress |
| busy_send | output | 1 | Send segment in progress |
| busy_recv | output | 1 | Receive segment in progress |
| done_cmd | output | 1 | Some segment has finished |
| done_tx | output | 1 | Send segment has finished |
| done_rx | output | 1 | Receive segment has finished |
| nack_flag | output | 1 | Last send was answered with NACK |
| rx_byte | output | 8 | Receive holding register |
| irq_done | output | 1 | Pulse on completion of any segment |
| irq_nack | output | 1 | Pulse on a NACK answer to a send |
| scl_in | input | 1 | Sensed SCL line level |
| sda_in | input | 1 | Sensed SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |

## Verification
The assertions assume the following about the inputs:
- Command strobes are single-cycle pulses.
- `scl_in` and `sda_in` are the wired-AND of the block's own enables and a slave that only ever pulls a line low.
- The slave changes SDA only while SCL is low, and it stretches SCL only by holding it low.

The bench keeps within these rules. It resolves both lines from the two sides through an open-drain model. Its slave changes SDA only one cycle after an observed SCL fall. Its stretch control only adds a pull-down on SCL. It pulses each strobe for exactly one cycle, so a pulse that lands while the block is busy or the bus is free tests the ignore rules and not a protocol violation.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_HOLD,
        S_START,
        S_BIT,
        S_STOP
    } seg_state_t;

    typedef enum logic [1:0] {
        K_START = 2'd0,
        K_STOP  = 2'd1,
        K_SEND  = 2'd2,
        K_RECV  = 2'd3
    } seg_kind_t;
endpackage

// File: rtl/i2cs_qtick.sv
module i2cs_qtick #(
    parameter int QDIV = 25
) (
    input  logic clk,
    input  logic rst_n,
    output logic qtick
);
    localparam int CW = (QDIV > 1) ? $clog2(QDIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(QDIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            qtick <= 1'b0;
        end else begin
            qtick <= (cnt == LAST);
            cnt   <= (cnt == LAST) ? '0 : cnt + 1'b1;
        end
    end
endmodule

// File: rtl/i2cs_fsm.sv
module i2cs_fsm
    import i2cs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       qtick,
    input  logic       go,
    input  seg_kind_t  kind,
    input  logic [7:0] tx_data,
    input  logic       ack_en,
    input  logic       scl_in,
    input  logic       sda_in,
    output logic       bus_free,
    output logic       bus_held,
    output logic       fin,
    output logic [7:0] rx_data,
    output logic       slave_nack,
    output logic       scl_oe,
    output logic       sda_oe
);
    localparam logic [3:0] LAST_BIT = 4'd8;

    seg_state_t state;
    logic [1:0] phase;
    logic [3:0] bitn;
    logic [7:0] shreg;
    logic       is_recv, ack_drv, from_hold, ackbit;

    // quarter advance, held back while SCL is released but still low
    logic step;
    assign step = qtick && !(phase == 2'd1 && !scl_in);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            phase     <= 2'd0;
            bitn      <= 4'd0;
            shreg     <= 8'd0;
            is_recv   <= 1'b0;
            ack_drv   <= 1'b0;
            from_hold <= 1'b0;
            ackbit    <= 1'b0;
            fin       <= 1'b0;
        end else begin
            fin <= 1'b0;
            unique case (state)
                S_IDLE, S_HOLD: begin
                    if (go) begin
                        phase     <= 2'd0;
                        bitn      <= 4'd0;
                        from_hold <= (state == S_HOLD);
                        is_recv   <= (kind == K_RECV);
                        ack_drv   <= ack_en;
                        if (kind == K_SEND) shreg <= tx_data;
                        unique case (kind)
                            K_START: state <= S_START;
                            K_STOP:  state <= S_STOP;
                            default: state <= S_BIT;
                        endcase
                    end
                end
                S_START, S_STOP: begin
                    if (step) begin
                        phase <= phase + 2'd1;
                        if (phase == 2'd3) begin
                            state <= (state == S_START) ? S_HOLD : S_IDLE;
                            fin   <= 1'b1;
                        end
                    end
                end
                S_BIT: begin
                    if (step) begin
                        phase <= phase + 2'd1;
                        if (phase == 2'd2) begin
                            if (bitn == LAST_BIT) ackbit <= sda_in;
                            else if (is_recv)     shreg  <= {shreg[6:0], sda_in};
                        end
                        if (phase == 2'd3) begin
                            if (bitn == LAST_BIT) begin
                                state <= S_HOLD;
                                fin   <= 1'b1;
                            end else begin
                                bitn <= bitn + 4'd1;
                                if (!is_recv) shreg <= {shreg[6:0], 1'b0};
                            end
                        end
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        scl_oe = 1'b0;
        sda_oe = 1'b0;
        unique case (state)
            S_IDLE: begin end
            S_HOLD: scl_oe = 1'b1;
            S_START: begin
                scl_oe = (phase == 2'd0) ? from_hold : (phase == 2'd3);
                sda_oe = phase[1];
            end
            S_BIT: begin
                scl_oe = (phase == 2'd0) || (phase == 2'd3);
                if (bitn == LAST_BIT) sda_oe = is_recv & ack_drv;
                else                  sda_oe = !is_recv & !shreg[7];
            end
            S_STOP: begin
                scl_oe = (phase == 2'd0);
                sda_oe = !phase[1];
            end
            default: begin end
        endcase
    end

    assign bus_free   = (state == S_IDLE);
    assign bus_held   = (state == S_HOLD);
    assign rx_data    = shreg;
    assign slave_nack = ackbit;

    // R3: data on SDA is steady for the whole time SCL is released inside a bit
    p_sda_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_BIT && $past(state) == S_BIT && !scl_oe && !$past(scl_oe))
        |-> $stable(sda_oe));

    // R3: completion is reported as a single-cycle pulse
    p_fin_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fin |=> !fin);

    // R8: only a start may be launched from a free bus
    p_free_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (go && bus_free) |-> (kind == K_START));

    // R11: a held-low SCL freezes the bit in its rising quarter
    p_stretch_wait_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_BIT && phase == 2'd1 && !scl_in) |=> (state == S_BIT && phase == 2'd1));

    // R6: leaving STOP both lines are released
    p_stop_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && $past(state) == S_STOP) |-> (!scl_oe && !sda_oe));
endmodule

// File: rtl/i2c_seg_master.sv
module i2c_seg_master
    import i2cs_pkg::*;
#(
    parameter int QDIV = 25
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_start,
    input  logic       cmd_stop,
    input  logic       cmd_send,
    input  logic       cmd_recv,
    input  logic       tx_wr,
    input  logic [7:0] tx_wdata,
    input  logic       ack_en,
    output logic       busy_start,
    output logic       busy_stop,
    output logic       busy_send,
    output logic       busy_recv,
    output logic       done_cmd,
    output logic       done_tx,
    output logic       done_rx,
    output logic       nack_flag,
    output logic [7:0] rx_byte,
    output logic       irq_done,
    output logic       irq_nack,
    input  logic       scl_in,
    input  logic       sda_in,
    output logic       scl_oe,
    output logic       sda_oe
);
    logic       qtick, bus_free, bus_held, fin, slave_nack;
    logic [7:0] rx_data, tx_hold;
    logic [3:0] busy_q;
    seg_kind_t  cur_kind, acc_kind;
    logic       acc;

    i2cs_qtick #(.QDIV(QDIV)) u_qtick (
        .clk   (clk),
        .rst_n (rst_n),
        .qtick (qtick)
    );

    i2cs_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .qtick      (qtick),
        .go         (acc),
        .kind       (acc_kind),
        .tx_data    (tx_hold),
        .ack_en     (ack_en),
        .scl_in     (scl_in),
        .sda_in     (sda_in),
        .bus_free   (bus_free),
        .bus_held   (bus_held),
        .fin        (fin),
        .rx_data    (rx_data),
        .slave_nack (slave_nack),
        .scl_oe     (scl_oe),
        .sda_oe     (sda_oe)
    );

    // strobe arbitration: start > stop > send > receive
    always_comb begin
        acc      = 1'b0;
        acc_kind = K_START;
        if (busy_q == 4'd0) begin
            if (cmd_start) begin
                acc = bus_free || bus_held;
            end else if (cmd_stop) begin
                acc = bus_held; acc_kind = K_STOP;
            end else if (cmd_send) begin
                acc = bus_held; acc_kind = K_SEND;
            end else if (cmd_recv) begin
                acc = bus_held; acc_kind = K_RECV;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_q    <= 4'd0;
            cur_kind  <= K_START;
            tx_hold   <= 8'd0;
            rx_byte   <= 8'd0;
            done_cmd  <= 1'b0;
            done_tx   <= 1'b0;
            done_rx   <= 1'b0;
            nack_flag <= 1'b0;
            irq_done  <= 1'b0;
            irq_nack  <= 1'b0;
        end else begin
            irq_done <= 1'b0;
            irq_nack <= 1'b0;
            if (tx_wr) tx_hold <= tx_wdata;
            if (acc) begin
                busy_q   <= 4'b0001 << acc_kind;
                cur_kind <= acc_kind;
                done_cmd <= 1'b0;
                if (acc_kind == K_SEND) begin
                    done_tx   <= 1'b0;
                    nack_flag <= 1'b0;
                end
                if (acc_kind == K_RECV) done_rx <= 1'b0;
            end
            if (fin) begin
                busy_q   <= 4'd0;
                done_cmd <= 1'b1;
                irq_done <= !done_cmd;
                if (cur_kind == K_SEND) begin
                    done_tx   <= 1'b1;
                    nack_flag <= slave_nack;
                    irq_nack  <= slave_nack;
                end
                if (cur_kind == K_RECV) begin
                    done_rx <= 1'b1;
                    rx_byte <= rx_data;
                end
            end
        end
    end

    assign busy_start = busy_q[0];
    assign busy_stop  = busy_q[1];
    assign busy_send  = busy_q[2];
    assign busy_recv  = busy_q[3];

    // R8: at most one command is busy at a time
    p_one_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(busy_q));

    // R8: on a free bus, nothing but a start can launch a segment
    p_idle_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_free && busy_q == 4'd0 && !cmd_start) |=> (busy_q == 4'd0));

    // R10: the completion interrupt marks a rising edge of done_cmd
    p_irq_edge_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_done |-> (done_cmd && !$past(done_cmd)));

    // R4: a NACK interrupt comes with the NACK status set
    p_irq_nack_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_nack |-> nack_flag);

    // R2: a busy bit only drops together with done_cmd rising
    p_busy_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_q != 4'd0) |-> done_cmd);
endmodule

// File: tb/i2c_seg_master_tb.sv
module i2c_seg_master_tb;
    localparam int QDIV = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic       cmd_start = 0, cmd_stop = 0, cmd_send = 0, cmd_recv = 0;
    logic       tx_wr = 0, ack_en = 0, stretch = 0;
    logic [7:0] tx_wdata = 0;
    logic       busy_start, busy_stop, busy_send, busy_recv;
    logic       done_cmd, done_tx, done_rx, nack_flag, irq_done, irq_nack;
    logic [7:0] rx_byte;
    logic       scl_oe, sda_oe;
    logic       slave_low = 1'b0;
    logic       scl_line, sda_line;

    assign scl_line = !(scl_oe || stretch);
    assign sda_line = !(sda_oe || slave_low);

    i2c_seg_master #(.QDIV(QDIV)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .cmd_start(cmd_start), .cmd_stop(cmd_stop), .cmd_send(cmd_send), .cmd_recv(cmd_recv),
        .tx_wr(tx_wr), .tx_wdata(tx_wdata), .ack_en(ack_en),
        .busy_start(busy_start), .busy_stop(busy_stop), .busy_send(busy_send), .busy_recv(busy_recv),
        .done_cmd(done_cmd), .done_tx(done_tx), .done_rx(done_rx), .nack_flag(nack_flag),
        .rx_byte(rx_byte), .irq_done(irq_done), .irq_nack(irq_nack),
        .scl_in(scl_line), .sda_in(sda_line), .scl_oe(scl_oe), .sda_oe(sda_oe)
    );

    int nchk = 0, nfail = 0;
    bit finished = 0;
    int seg_cnt = 0, nack_cnt = 0;

    // slave arming, written only by the stimulus
    int         arm_seq = 0, arm_mode = 0;
    logic       arm_ack = 0;
    logic [7:0] arm_data = 0;

    // slave / monitor state, written only by the model
    int         last_arm = 0, rise_cnt = 0, fall_cnt = 0;
    int         n_start = 0, n_stop = 0, n_irq = 0, n_nirq = 0, irq_wide = 0;
    logic [7:0] cap = 0;
    logic       mack_low = 0, prev_scl = 1, prev_sda = 1, prev_irq = 0;

    function automatic logic [7:0] fmt7(input logic [6:0] a, input logic rw);
        return {a, rw};
    endfunction
    function automatic logic [7:0] fmt10_hi(input logic [9:0] a, input logic rw);
        return {5'b11110, a[9:8], rw};
    endfunction
    function automatic logic [7:0] fmt10_lo(input logic [9:0] a);
        return a[7:0];
    endfunction
    function automatic logic exp_nack(input logic slave_acks);
        return !slave_acks;
    endfunction
    function automatic logic exp_mack(input logic ae);
        return ae;
    endfunction

    always @(negedge clk) begin
        if (arm_seq != last_arm) begin
            last_arm  = arm_seq;
            rise_cnt  = 0;
            fall_cnt  = 0;
            cap       = 8'd0;
            mack_low  = 1'b0;
            slave_low = (arm_mode == 2) ? !arm_data[7] : 1'b0;
        end
        if (scl_line && !prev_scl) begin
            if (rise_cnt < 8) cap = {cap[6:0], sda_line};
            else if (rise_cnt == 8) mack_low = !sda_line;
            rise_cnt++;
        end
        if (!scl_line && prev_scl) begin
            if (arm_mode == 1) slave_low = (fall_cnt == 7) ? arm_ack : 1'b0;
            else if (arm_mode == 2) slave_low = (fall_cnt < 7) ? !arm_data[6 - fall_cnt] : 1'b0;
            fall_cnt++;
        end
        if (scl_line && prev_scl && prev_sda && !sda_line) n_start++;
        if (scl_line && prev_scl && !prev_sda && sda_line) n_stop++;
        if (irq_done) n_irq++;
        if (irq_done && prev_irq) irq_wide++;
        if (irq_nack) n_nirq++;
        prev_scl = scl_line;
        prev_sda = sda_line;
        prev_irq = irq_done;
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic [3:0] m);
        @(negedge clk);
        {cmd_recv, cmd_send, cmd_stop, cmd_start} = m;
        @(negedge clk);
        {cmd_recv, cmd_send, cmd_stop, cmd_start} = 4'd0;
    endtask

    task automatic arm(input int mode, input logic ack, input logic [7:0] d);
        @(negedge clk);
        arm_mode = mode;
        arm_ack  = ack;
        arm_data = d;
        arm_seq++;
    endtask

    task automatic load_tx(input logic [7:0] b);
        @(negedge clk);
        tx_wr = 1'b1;
        tx_wdata = b;
        @(negedge clk);
        tx_wr = 1'b0;
    endtask

    task automatic wait_free(input string tag);
        int n = 0;
        while ((busy_start || busy_stop || busy_send || busy_recv) && n < 5000) begin
            @(negedge clk);
            n++;
        end
        chk(n < 5000, tag, n, 0);
        seg_cnt++;
    endtask

    task automatic seg_start(input string tag);
        int s0 = n_start;
        arm(0, 1'b0, 8'd0);
        issue(4'b0001);
        chk(busy_start == 1'b1, tag, busy_start, 1);
        wait_free(tag);
        chk(n_start == s0 + 1, tag, n_start, s0 + 1);
        chk(done_cmd && !scl_line, tag, {done_cmd, scl_line}, 2'b10);
    endtask

    task automatic seg_send(input logic [7:0] b, input logic acks);
        load_tx(b);
        arm(1, acks, 8'd0);
        issue(4'b0100);
        chk(busy_send == 1'b1, "R3 busy", busy_send, 1);
        wait_free("R3 done");
        chk(cap == b, "R3 byte", cap, b);
        chk(nack_flag == exp_nack(acks), "R4 nack", nack_flag, exp_nack(acks));
        chk(done_tx && done_cmd, "R3 flags", {done_tx, done_cmd}, 2'b11);
        if (!acks) nack_cnt++;
    endtask

    task automatic seg_recv(input logic [7:0] b, input logic ae);
        ack_en = ae;
        arm(2, 1'b0, b);
        issue(4'b1000);
        chk(busy_recv == 1'b1, "R5 busy", busy_recv, 1);
        wait_free("R5 done");
        chk(rx_byte == b, "R5 byte", rx_byte, b);
        chk(mack_low == exp_mack(ae), "R5 ack drive", mack_low, exp_mack(ae));
        chk(done_rx == 1'b1, "R5 flag", done_rx, 1);
    endtask

    task automatic seg_stop();
        int s0 = n_stop;
        arm(0, 1'b0, 8'd0);
        issue(4'b0010);
        chk(busy_stop == 1'b1, "R6 busy", busy_stop, 1);
        wait_free("R6 done");
        chk(n_stop == s0 + 1, "R6 stop cond", n_stop, s0 + 1);
        chk(scl_line && sda_line, "R6 released", {scl_line, sda_line}, 2'b11);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            nchk++;
            nfail++;
            $display("FAIL R2 watchdog: actual hung expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_2024));
        repeat (5) @(negedge clk);
        // R1 reset state
        chk({busy_start, busy_stop, busy_send, busy_recv} == 4'd0, "R1 busy", {busy_start, busy_stop, busy_send, busy_recv}, 0);
        chk({done_cmd, done_tx, done_rx, nack_flag, irq_done, irq_nack} == 6'd0, "R1 flags",
            {done_cmd, done_tx, done_rx, nack_flag, irq_done, irq_nack}, 0);
        chk(!scl_oe && !sda_oe && rx_byte == 8'd0, "R1 pins", {scl_oe, sda_oe, rx_byte}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R8: non-start commands on a free bus are ignored
        issue(4'b0100);
        chk(busy_send == 1'b0, "R8 send on free bus", busy_send, 0);
        issue(4'b0010);
        chk(busy_stop == 1'b0, "R8 stop on free bus", busy_stop, 0);
        issue(4'b1000);
        chk(busy_recv == 1'b0, "R8 recv on free bus", busy_recv, 0);
        repeat (20) @(negedge clk);
        chk(scl_line && sda_line && !done_cmd, "R8 bus untouched", {scl_line, sda_line, done_cmd}, 3'b110);

        // directed frame
        seg_start("R2 start");
        load_tx(fmt7(7'h52, 1'b0));
        arm(1, 1'b1, 8'd0);
        issue(4'b0100);
        issue(4'b0001);
        chk(busy_start == 1'b0 && busy_send == 1'b1, "R8 start while busy", {busy_start, busy_send}, 2'b01);
        wait_free("R3 done");
        chk(cap == fmt7(7'h52, 1'b0), "R3 address byte", cap, fmt7(7'h52, 1'b0));
        seg_recv(8'hA5, 1'b1);
        seg_recv(8'h00, 1'b0);
        seg_send(8'h3C, 1'b0);
        chk(nack_flag == 1'b1, "R4 nack set", nack_flag, 1);
        // R9: flags clear on the next command of the same kind
        load_tx(8'hC3);
        arm(1, 1'b1, 8'd0);
        issue(4'b0100);
        chk(!nack_flag && !done_tx && !done_cmd && done_rx, "R9 flag clear",
            {nack_flag, done_tx, done_cmd, done_rx}, 4'b0001);
        wait_free("R9 done");
        chk(cap == 8'hC3 && !nack_flag, "R9 send after clear", {cap, nack_flag}, {8'hC3, 1'b0});

        // R7 repeated start, then a 10-bit address with a stretched second byte
        seg_start("R7 restart");
        seg_send(fmt10_hi(10'h2F1, 1'b0), 1'b1);
        load_tx(fmt10_lo(10'h2F1));
        arm(1, 1'b1, 8'd0);
        stretch = 1'b1;
        issue(4'b0100);
        repeat (100) @(negedge clk);
        chk(busy_send && rise_cnt == 0, "R11 stalled", {busy_send, 8'(rise_cnt)}, {1'b1, 8'd0});
        stretch = 1'b0;
        wait_free("R11 done");
        chk(cap == fmt10_lo(10'h2F1), "R11 byte intact", cap, fmt10_lo(10'h2F1));

        // R8 priority: stop wins over send
        arm(0, 1'b0, 8'd0);
        issue(4'b0110);
        chk(busy_stop && !busy_send, "R8 priority", {busy_stop, busy_send}, 2'b10);
        wait_free("R6 done");
        chk(scl_line && sda_line, "R6 released", {scl_line, sda_line}, 2'b11);

        // random frames
        for (int f = 0; f < 12; f++) begin
            logic [9:0] a10;
            logic       rw;
            int         nseg;
            a10 = 10'($urandom);
            rw  = 1'($urandom);
            seg_start("R2 start");
            if ($urandom % 2 == 0) begin
                seg_send(fmt7(a10[6:0], rw), 1'b1);
            end else begin
                seg_send(fmt10_hi(a10, rw), 1'b1);
                seg_send(fmt10_lo(a10), 1'b1);
            end
            nseg = 1 + ($urandom % 3);
            for (int s = 0; s < nseg; s++) begin
                if ($urandom % 4 == 0) seg_start("R7 restart");
                if ($urandom % 2 == 0) seg_send(8'($urandom), 1'($urandom % 4 != 0));
                else                   seg_recv(8'($urandom), 1'($urandom));
            end
            seg_stop();
        end

        repeat (4) @(negedge clk);
        chk(n_irq == seg_cnt, "R10 irq count", n_irq, seg_cnt);
        chk(irq_wide == 0, "R10 single pulse", irq_wide, 0);
        chk(n_nirq == nack_cnt, "R4 nack irq count", n_nirq, nack_cnt);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule